// File: doc/BRIEF.md
# Stepping Digit Sequencer with Seven-Segment Display

The block holds a fixed list of nine decimal digits as build-time constants and walks through them one position at a time. A single control input, `data_in`, decides on each rising clock edge whether the machine moves on to the next position or stays where it is. After the ninth position the walk returns to the first. An active-low reset, `resetn`, returns the machine to the first position at once, without waiting for a clock edge.

Two active-low seven-segment outputs show the walk. One shows the position number, from 1 to 9. The other shows the digit stored at that position. A row of active-high LEDs marks the current position with one lit LED.

A build parameter selects the output style. In the Moore style the digit display depends only on the stored position. In the Mealy style the digit display also follows `data_in`: while it is high, the display shows the digit of the position the machine is about to enter. Any stored digit outside 0..9 is shown as the letter E. A position register that holds a code outside the nine legal ones also shows E on both displays, and on the next clock edge it returns to the first position.

Top module: `digit_seq_display`

## Requirements
- R1: While `resetn` is low, and without waiting for a clock edge, the machine is at position 1: `state_seg` shows 1, `digit_seg` shows the first digit, and only `led[0]` is lit.
- R2: On a rising clock edge with `data_in`=1, the position moves from k to k+1 for k from 1 to 8.
- R3: On a rising clock edge with `data_in`=0, the position, both displays and the LEDs stay unchanged (Moore build).
- R4: On a rising clock edge with `data_in`=1 at position 9, the position returns to 1.
- R5: The segment outputs are active low, with bit 0 driving segment a and bit 6 driving segment g. The patterns are 0=7'b1000000, 1=7'b1111001, 2=7'b0100100, 3=7'b0110000, 4=7'b0011001, 5=7'b0010010, 6=7'b0000010, 7=7'b1111000, 8=7'b0000000 and 9=7'b0010000. `state_seg` shows the position number.
- R6: In the Moore build (`MEALY`=0), `digit_seg` shows the digit of the current position, whatever the level of `data_in`. The default digits are 5,0,0,4,3,5,4,2,9 for positions 1 to 9.
- R7: In the Mealy build (`MEALY`=1), `digit_seg` shows the digit of the next position (9 is followed by 1) while `data_in`=1, and the digit of the current position while `data_in`=0.
- R8: A digit value of 10 to 15 is shown as E. E lights segments a, d, e, f and g, which gives the active-low pattern 7'b0000110.
- R9: `led` is active high and has exactly one bit set: bit k-1 while the machine is at position k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| resetn | input | 1 | Asynchronous active-low reset to position 1 |
| data_in | input | 1 | 1 advances on the next edge, 0 holds; also steers the digit display in the Mealy build |
| state_seg | output | 7 | Active-low segments {g,f,e,d,c,b,a} showing the position number |
| digit_seg | output | 7 | Active-low segments {g,f,e,d,c,b,a} showing the selected digit |
| led | output | N_DIG | Active-high one-hot position marker |

## Verification
The position changes on the rising edge that samples `data_in`. Both displays and the LEDs are decoded combinationally from that register, so they are due in the same cycle as the edge, with no extra latency. In the Mealy build, `digit_seg` also follows `data_in` within the same cycle. The bench therefore drives `data_in` on the falling edge and compares all outputs 1 ns later against a model that is updated only at the rising edge. Reset is checked 1 ns after `resetn` falls in the middle of a cycle, which shows that it acts without a clock edge.

// File: rtl/digit_seq_pkg.sv
package digit_seq_pkg;

  localparam int SEG_W = 7;

  // Active-low glyph for the letter E (segments a, d, e, f and g lit).
  localparam logic [SEG_W-1:0] GLYPH_E = 7'b0000110;

  // Converts a 4-bit value to an active-low {g,f,e,d,c,b,a} pattern.
  // Values 10 to 15 map to E.
  function automatic logic [SEG_W-1:0] seg_of(input logic [3:0] v);
    case (v)
      4'd0:    return 7'b1000000;
      4'd1:    return 7'b1111001;
      4'd2:    return 7'b0100100;
      4'd3:    return 7'b0110000;
      4'd4:    return 7'b0011001;
      4'd5:    return 7'b0010010;
      4'd6:    return 7'b0000010;
      4'd7:    return 7'b1111000;
      4'd8:    return 7'b0000000;
      4'd9:    return 7'b0010000;
      default: return GLYPH_E;
    endcase
  endfunction

endpackage

// File: rtl/digit_seq_ctrl.sv
module digit_seq_ctrl #(
  parameter int N_DIG = 9,
  parameter int IDX_W = $clog2(N_DIG)
) (
  input  logic             clk,
  input  logic             resetn,
  input  logic             adv,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] succ,
  output logic             legal
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_DIG - 1);

  logic [IDX_W-1:0] idx_d;

  // A position code is legal only if it indexes one of the N_DIG digits.
  assign legal = (idx_q <= LAST);

  // The successor of the last position, or of an illegal code, is position 1.
  assign succ = (idx_q >= LAST) ? '0 : idx_q + 1'b1;

  always_comb begin
    if (!legal)   idx_d = '0;
    else if (adv) idx_d = succ;
    else          idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge resetn) begin
    if (!resetn) idx_q <= '0;
    else         idx_q <= idx_d;
  end

endmodule

// File: rtl/digit_seq_pick.sv
module digit_seq_pick #(
  parameter int                 N_DIG  = 9,
  parameter int                 IDX_W  = $clog2(N_DIG),
  parameter bit                 MEALY  = 1'b0,
  parameter logic [4*N_DIG-1:0] DIGITS = 36'h924534005
) (
  input  logic [IDX_W-1:0] idx_q,
  input  logic [IDX_W-1:0] succ,
  input  logic             adv,
  output logic [3:0]       value
);

  // Returns the digit stored at position index i. An index outside the
  // list returns 15, which the decoder shows as E.
  function automatic logic [3:0] digit_at(input logic [IDX_W-1:0] i);
    logic [3:0] r;
    r = 4'hF;
    for (int k = 0; k < N_DIG; k++)
      if (i == IDX_W'(k)) r = DIGITS[4*k +: 4];
    return r;
  endfunction

  logic [IDX_W-1:0] sel;

  generate
    if (MEALY) begin : g_mealy
      assign sel = adv ? succ : idx_q;
    end else begin : g_moore
      assign sel = idx_q;
    end
  endgenerate

  assign value = digit_at(sel);

endmodule

// File: rtl/digit_seq_seg.sv
module digit_seq_seg
  import digit_seq_pkg::*;
(
  input  logic [3:0]       value,
  input  logic             force_e,
  output logic [SEG_W-1:0] seg
);

  assign seg = force_e ? GLYPH_E : seg_of(value);

endmodule

// File: rtl/digit_seq_display.sv
module digit_seq_display
  import digit_seq_pkg::*;
#(
  parameter int                 N_DIG  = 9,
  parameter bit                 MEALY  = 1'b0,
  parameter logic [4*N_DIG-1:0] DIGITS = 36'h924534005
) (
  input  logic             clk,
  input  logic             resetn,
  input  logic             data_in,
  output logic [SEG_W-1:0] state_seg,
  output logic [SEG_W-1:0] digit_seg,
  output logic [N_DIG-1:0] led
);

  localparam int IDX_W = (N_DIG > 1) ? $clog2(N_DIG) : 1;

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] succ;
  logic             legal;
  logic [3:0]       dig_val;
  logic [3:0]       pos_num;

  digit_seq_ctrl #(.N_DIG(N_DIG), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .resetn(resetn), .adv(data_in),
    .idx_q(idx_q), .succ(succ), .legal(legal)
  );

  digit_seq_pick #(.N_DIG(N_DIG), .IDX_W(IDX_W), .MEALY(MEALY),
                   .DIGITS(DIGITS)) u_pick (
    .idx_q(idx_q), .succ(succ), .adv(data_in), .value(dig_val)
  );

  // The position number is the index plus one.
  assign pos_num = 4'(idx_q) + 4'd1;

  digit_seq_seg u_seg_state (.value(pos_num), .force_e(!legal), .seg(state_seg));
  digit_seq_seg u_seg_digit (.value(dig_val), .force_e(!legal), .seg(digit_seg));

  generate
    for (genvar k = 0; k < N_DIG; k++) begin : g_led
      assign led[k] = (idx_q == IDX_W'(k));
    end
  endgenerate

endmodule

// File: rtl/digit_seq_chk.sv
module digit_seq_chk #(
  parameter int N_DIG = 9,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             resetn,
  input logic             data_in,
  input logic [IDX_W-1:0] idx_q,
  input logic [N_DIG-1:0] led
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_DIG - 1);

  p_hold_r3: assert property (@(posedge clk) disable iff (!resetn)
    (!data_in && idx_q <= LAST) |=> $stable(idx_q));

  p_advance_r2: assert property (@(posedge clk) disable iff (!resetn)
    (data_in && idx_q < LAST) |=> (idx_q == $past(idx_q) + 1'b1));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!resetn)
    (data_in && idx_q == LAST) |=> (idx_q == '0));

  p_led_onehot_r9: assert property (@(posedge clk) disable iff (!resetn)
    $countones(led) == 1);

  p_led_moves_r9: assert property (@(posedge clk) disable iff (!resetn)
    (!data_in) |=> $stable(led));

endmodule

bind digit_seq_display digit_seq_chk #(.N_DIG(N_DIG), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .resetn(resetn), .data_in(data_in), .idx_q(idx_q), .led(led)
);

// File: tb/digit_seq_display_tb.sv
module digit_seq_display_tb;

  logic clk = 1'b0;
  logic resetn = 1'b0;
  logic data_in = 1'b0;
  logic [6:0] state_seg, digit_seg, m_state_seg, m_digit_seg;
  logic [8:0] led, m_led;

  int checks = 0;
  int errors = 0;
  int pos = 0;  // model position index, 0..8
  bit done = 1'b0;

  int dig_a[9] = '{5, 0, 0, 4, 3, 5, 4, 2, 9};
  int dig_b[9] = '{5, 0, 0, 4, 12, 5, 4, 2, 9};

  always #5 clk = ~clk;

  digit_seq_display u_dut (
    .clk(clk), .resetn(resetn), .data_in(data_in),
    .state_seg(state_seg), .digit_seg(digit_seg), .led(led)
  );

  digit_seq_display #(.MEALY(1'b1), .DIGITS(36'h9245C4005)) u_mealy (
    .clk(clk), .resetn(resetn), .data_in(data_in),
    .state_seg(m_state_seg), .digit_seg(m_digit_seg), .led(m_led)
  );

  // Lit segments in active-high form (a in bit 0), inverted to active low.
  function automatic logic [6:0] glyph(input int v);
    logic [6:0] on;
    case (v)
      0: on = 7'h3F;  1: on = 7'h06;  2: on = 7'h5B;  3: on = 7'h4F;
      4: on = 7'h66;  5: on = 7'h6D;  6: on = 7'h7D;  7: on = 7'h07;
      8: on = 7'h7F;  9: on = 7'h6F;
      default: on = 7'h79;  // E
    endcase
    return ~on;
  endfunction

  function automatic int nxt(input int p);
    return (p == 8) ? 0 : p + 1;
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%h expected=%h", req, pos + 1, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R5 state_seg"}, {2'b0, state_seg}, {2'b0, glyph(pos + 1)});
    chk({tag, " R6 moore digit"}, {2'b0, digit_seg}, {2'b0, glyph(dig_a[pos])});
    chk({tag, " R9 led"}, led, 9'(1 << pos));
    chk({tag, " R5 mealy state_seg"}, {2'b0, m_state_seg}, {2'b0, glyph(pos + 1)});
    chk({tag, " R7/R8 mealy digit"}, {2'b0, m_digit_seg},
        {2'b0, glyph(data_in ? dig_b[nxt(pos)] : dig_b[pos])});
  endtask

  // Drive on the falling edge, check 1 ns later, then update the model at the rising edge.
  task automatic step(input bit din, input string tag);
    @(negedge clk);
    data_in = din;
    #1;
    check_all(tag);
    @(posedge clk);
    if (din) pos = nxt(pos);
  endtask

  initial begin
    #20000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    #1;
    // R1: reset state
    check_all("R1 reset");
    chk("R8 E glyph", {2'b0, glyph(12)}, 9'b000000110);
    repeat (2) @(posedge clk);
    @(negedge clk) resetn = 1'b1;

    // R2/R4: a full lap plus one, through the wrap
    for (int i = 0; i < 10; i++) step(1'b1, "R2 R4 lap");
    // R3: hold
    for (int i = 0; i < 4; i++) step(1'b0, "R3 hold");
    // Park at position 5 so the E digit shows on the Mealy instance (R8).
    while (pos != 4) step(1'b1, "R2 seek");
    step(1'b0, "R8 E current");
    // Random walk with data_in high about 60% of the time.
    for (int i = 0; i < 400; i++) step(($urandom % 10) < 6, "R2 R3 rand");

    // R1: asynchronous reset in the middle of a cycle
    while (pos == 0) step(1'b1, "R2 leave");
    @(negedge clk);
    data_in = 1'b0;
    #2 resetn = 1'b0;
    #1 pos = 0;
    check_all("R1 async");
    @(negedge clk) resetn = 1'b1;
    for (int i = 0; i < 12; i++) step(1'b1, "R4 post");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule